// File: doc/BRIEF.md
# Givens Rotation CORDIC Node

This block is one processing element of a systolic QR-decomposition array. Each cycle it takes a pair of signed fixed-point samples (X, Y) together with a mode bit and an enable bit. When the mode bit selects vectoring, the node turns the pair onto the positive horizontal axis. It reports the corrected length of the vector on the horizontal output and zero on the vertical output, and it keeps the angle it used. When the mode bit selects rotating, the node turns the incoming pair by that kept angle and reports both rotated components. Within one matrix, the first pair in a node is vectored and every later pair is rotated. All rotations of that matrix therefore share one angle.

The arithmetic is a pipelined shift-and-add CORDIC. A quadrant pre-rotation stage comes first, then `ITER` micro-rotation stages, then one output stage. The output stage removes the CORDIC gain with a single fixed-point constant near 0.60725, rounds, saturates and selects the outputs. The node never stores the angle as a number. Each stage keeps the rotation direction it chose for the last enabled vectoring pair, so a rotating pair replays exactly the same sequence of micro-rotations. The mode and enable bits travel through the pipeline with the data, which lets the next node in the array see them aligned with its own data. With default parameters the node latency is 15 cycles.

Top module: `givens_node`

## Requirements
- R1: While reset is held, and after it is released until the first pair has crossed the pipeline, `out_h`, `out_v`, `out_vec` and `out_en` are all zero.
- R2: `out_vec` and `out_en` equal `in_vec` and `in_en` from exactly 15 cycles earlier (default parameters), whatever the data.
- R3: For an enabled pair with `in_vec`=1, `out_h` 15 cycles later is the length sqrt(X²+Y²) in Q1.14 (16-bit signed, 14 fraction bits), within 6 LSB, in all four quadrants.
- R4: For an enabled pair with `in_vec`=1, `out_v` 15 cycles later is exactly zero.
- R5: For an enabled pair with `in_vec`=0, the outputs are h = X·cosθ + Y·sinθ and v = −X·sinθ + Y·cosθ in Q1.14, within 16 LSB. Here θ = atan2(Yv, Xv) of the most recent enabled vectoring pair (Xv, Yv).
- R6: The kept angle stays the same across any number of rotating pairs. A new enabled vectoring pair changes the angle only for pairs that enter after it, including a rotating pair in the very next cycle.
- R7: When `in_en`=0, `out_h` and `out_v` are zero 15 cycles later, and a pair with `in_vec`=1 does not change the kept angle.
- R8: A result outside the Q1.14 range is clamped to 32767 or −32768.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_x | input | 16 | X sample, signed Q1.14 |
| in_y | input | 16 | Y sample, signed Q1.14 |
| in_vec | input | 1 | 1 = vectoring (capture angle), 0 = rotating |
| in_en | input | 1 | Output enable for this pair |
| out_h | output | 16 | Horizontal result, signed Q1.14 |
| out_v | output | 16 | Vertical result, signed Q1.14 |
| out_vec | output | 1 | Mode bit delayed by the node latency |
| out_en | output | 1 | Enable bit delayed by the node latency |

## Verification
The hardest case to reach from the ports is a change of angle while the pipeline is full. Older rotating pairs must still finish with the old direction bits, while the pairs behind a new vectoring pair must use the new ones. The stimulus streams pairs back to back with no idle cycles. A vectoring pair is followed in the very next cycle by a rotating pair, and rotating pairs that precede it are still in flight. A disabled vectoring pair is also placed in the middle of a matrix, and the rotations that follow show whether it changed the angle. Angles are swept in 15-degree steps over the full circle at three radii, with rotations checked against real-valued trigonometry after each capture.

// File: rtl/givens_pkg.sv
package givens_pkg;

  // Coarse rotation chosen by the pre-rotation stage
  typedef enum logic [1:0] {
    QUAD_KEEP = 2'd0,   // no coarse turn
    QUAD_CW   = 2'd1,   // turn by -90 degrees
    QUAD_CCW  = 2'd2    // turn by +90 degrees
  } quad_e;

endpackage

// File: rtl/givens_prerot.sv
module givens_prerot
  import givens_pkg::*;
#(
  parameter int IW = 21
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic signed [IW-1:0] x_i,
  input  logic signed [IW-1:0] y_i,
  input  logic                 vec_i,
  input  logic                 en_i,
  output logic signed [IW-1:0] x_o,
  output logic signed [IW-1:0] y_o,
  output logic                 vec_o,
  output logic                 en_o
);

  quad_e quad_q;
  quad_e quad_new;
  quad_e quad_use;
  logic  capture;

  assign capture = en_i & vec_i;

  always_comb begin
    if (x_i < 0) begin
      quad_new = (y_i >= 0) ? QUAD_CW : QUAD_CCW;
    end else begin
      quad_new = QUAD_KEEP;
    end
    quad_use = capture ? quad_new : quad_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      quad_q <= QUAD_KEEP;
      x_o    <= '0;
      y_o    <= '0;
      vec_o  <= 1'b0;
      en_o   <= 1'b0;
    end else begin
      if (capture) begin
        quad_q <= quad_new;
      end
      unique case (quad_use)
        QUAD_CW: begin
          x_o <= y_i;
          y_o <= -x_i;
        end
        QUAD_CCW: begin
          x_o <= -y_i;
          y_o <= x_i;
        end
        default: begin
          x_o <= x_i;
          y_o <= y_i;
        end
      endcase
      vec_o <= vec_i;
      en_o  <= en_i;
    end
  end

  // R3
  vec_axis_chk: assert property (@(posedge clk) disable iff (rst)
    (en_i && vec_i) |=> (x_o >= 0));

  // R7
  quad_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(en_i && vec_i) |=> $stable(quad_q));

endmodule

// File: rtl/givens_micro.sv
module givens_micro #(
  parameter int IW    = 21,
  parameter int SHIFT = 0
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic signed [IW-1:0] x_i,
  input  logic signed [IW-1:0] y_i,
  input  logic                 vec_i,
  input  logic                 en_i,
  output logic signed [IW-1:0] x_o,
  output logic signed [IW-1:0] y_o,
  output logic                 vec_o,
  output logic                 en_o
);

  logic                 dir_q;     // 1: last captured step raised y
  logic                 capture;
  logic                 neg_new;
  logic                 neg_use;
  logic signed [IW-1:0] x_sh;
  logic signed [IW-1:0] y_sh;

  assign capture = en_i & vec_i;
  assign neg_new = (y_i < 0);
  assign neg_use = capture ? neg_new : dir_q;
  assign x_sh    = x_i >>> SHIFT;
  assign y_sh    = y_i >>> SHIFT;

  always_ff @(posedge clk) begin
    if (rst) begin
      dir_q <= 1'b0;
      x_o   <= '0;
      y_o   <= '0;
      vec_o <= 1'b0;
      en_o  <= 1'b0;
    end else begin
      if (capture) begin
        dir_q <= neg_new;
      end
      if (neg_use) begin
        x_o <= x_i - y_sh;
        y_o <= y_i + x_sh;
      end else begin
        x_o <= x_i + y_sh;
        y_o <= y_i - x_sh;
      end
      vec_o <= vec_i;
      en_o  <= en_i;
    end
  end

  // R3
  vec_grow_chk: assert property (@(posedge clk) disable iff (rst)
    (en_i && vec_i) |=> (x_o >= $past(x_i)));

  // R6
  dir_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(en_i && vec_i) |=> $stable(dir_q));

endmodule

// File: rtl/givens_outsel.sv
module givens_outsel #(
  parameter int IW    = 21,
  parameter int DW    = 16,
  parameter int GUARD = 2,
  parameter int GF    = 16,
  parameter int GAIN  = 39797
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic signed [IW-1:0] x_i,
  input  logic signed [IW-1:0] y_i,
  input  logic                 vec_i,
  input  logic                 en_i,
  output logic signed [DW-1:0] h_o,
  output logic signed [DW-1:0] v_o,
  output logic                 vec_o,
  output logic                 en_o
);

  localparam int PW = IW + GF + 2;
  localparam int SH = GF + GUARD;
  localparam logic signed [PW-1:0] GAIN_W = PW'(GAIN);
  localparam logic signed [PW-1:0] RND    = PW'(2 ** (SH - 1));
  localparam logic signed [PW-1:0] SAT_HI = PW'((2 ** (DW - 1)) - 1);
  localparam logic signed [PW-1:0] SAT_LO = ~SAT_HI;

  logic signed [PW-1:0] prod_h;
  logic signed [PW-1:0] prod_v;
  logic signed [PW-1:0] scl_h;
  logic signed [PW-1:0] scl_v;
  logic signed [DW-1:0] sat_h;
  logic signed [DW-1:0] sat_v;

  function automatic logic signed [DW-1:0] clamp(input logic signed [PW-1:0] val);
    if (val > SAT_HI) begin
      return SAT_HI[DW-1:0];
    end else if (val < SAT_LO) begin
      return SAT_LO[DW-1:0];
    end else begin
      return val[DW-1:0];
    end
  endfunction

  always_comb begin
    prod_h = PW'(x_i) * GAIN_W;
    prod_v = PW'(y_i) * GAIN_W;
    scl_h  = (prod_h + RND) >>> SH;
    scl_v  = (prod_v + RND) >>> SH;
    sat_h  = clamp(scl_h);
    sat_v  = clamp(scl_v);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      h_o   <= '0;
      v_o   <= '0;
      vec_o <= 1'b0;
      en_o  <= 1'b0;
    end else begin
      h_o   <= en_i ? sat_h : '0;
      v_o   <= (en_i && !vec_i) ? sat_v : '0;
      vec_o <= vec_i;
      en_o  <= en_i;
    end
  end

  // R7
  off_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !en_i |=> (h_o == 0 && v_o == 0));

  // R4
  vec_v_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (en_i && vec_i) |=> (v_o == 0));

  // R2
  ctl_follow_chk: assert property (@(posedge clk) disable iff (rst)
    en_o |-> $past(en_i, 1) || !$past(en_i, 1) == !en_o);

endmodule

// File: rtl/givens_node.sv
module givens_node #(
  parameter int DW    = 16,
  parameter int HEAD  = 3,
  parameter int GUARD = 2,
  parameter int ITER  = 13,
  parameter int GF    = 16,
  parameter int GAIN  = 39797
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic signed [DW-1:0] in_x,
  input  logic signed [DW-1:0] in_y,
  input  logic                 in_vec,
  input  logic                 in_en,
  output logic signed [DW-1:0] out_h,
  output logic signed [DW-1:0] out_v,
  output logic                 out_vec,
  output logic                 out_en
);

  localparam int IW = DW + HEAD + GUARD;

  logic signed [IW-1:0] x_ext;
  logic signed [IW-1:0] y_ext;

  logic signed [IW-1:0] xs [ITER+1];
  logic signed [IW-1:0] ys [ITER+1];
  logic                 vs [ITER+1];
  logic                 es [ITER+1];

  assign x_ext = {{HEAD{in_x[DW-1]}}, in_x, {GUARD{1'b0}}};
  assign y_ext = {{HEAD{in_y[DW-1]}}, in_y, {GUARD{1'b0}}};

  givens_prerot #(.IW(IW)) u_prerot (
    .clk  (clk),
    .rst  (rst),
    .x_i  (x_ext),
    .y_i  (y_ext),
    .vec_i(in_vec),
    .en_i (in_en),
    .x_o  (xs[0]),
    .y_o  (ys[0]),
    .vec_o(vs[0]),
    .en_o (es[0])
  );

  for (genvar k = 0; k < ITER; k++) begin : g_iter
    givens_micro #(.IW(IW), .SHIFT(k)) u_micro (
      .clk  (clk),
      .rst  (rst),
      .x_i  (xs[k]),
      .y_i  (ys[k]),
      .vec_i(vs[k]),
      .en_i (es[k]),
      .x_o  (xs[k+1]),
      .y_o  (ys[k+1]),
      .vec_o(vs[k+1]),
      .en_o (es[k+1])
    );
  end

  givens_outsel #(
    .IW   (IW),
    .DW   (DW),
    .GUARD(GUARD),
    .GF   (GF),
    .GAIN (GAIN)
  ) u_outsel (
    .clk  (clk),
    .rst  (rst),
    .x_i  (xs[ITER]),
    .y_i  (ys[ITER]),
    .vec_i(vs[ITER]),
    .en_i (es[ITER]),
    .h_o  (out_h),
    .v_o  (out_v),
    .vec_o(out_vec),
    .en_o (out_en)
  );

endmodule

// File: tb/test_givens_node.sv
module test_givens_node;

  localparam int  LAT   = 15;
  localparam int  SLOTS = 1024;
  localparam real FS    = 16384.0;
  localparam real PI    = 3.14159265358979;

  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic signed [15:0] in_x = '0;
  logic signed [15:0] in_y = '0;
  logic               in_vec = 1'b0;
  logic               in_en = 1'b0;
  logic signed [15:0] out_h;
  logic signed [15:0] out_v;
  logic               out_vec;
  logic               out_en;

  int    checks = 0;
  int    fails  = 0;
  int    cyc    = 0;
  real   ang_m  = 0.0;

  int    exp_h   [SLOTS];
  int    exp_v   [SLOTS];
  int    tol_h   [SLOTS];
  int    tol_v   [SLOTS];
  int    exp_vec [SLOTS];
  int    exp_en  [SLOTS];
  string tag_h   [SLOTS];
  string tag_v   [SLOTS];

  always #4 clk = ~clk;

  givens_node i_givens_node (
    .clk    (clk),
    .rst    (rst),
    .in_x   (in_x),
    .in_y   (in_y),
    .in_vec (in_vec),
    .in_en  (in_en),
    .out_h  (out_h),
    .out_v  (out_v),
    .out_vec(out_vec),
    .out_en (out_en)
  );

  function automatic int qfix(input real v);
    real r;
    r = v * FS;
    if (r > 32767.0) return 32767;
    if (r < -32768.0) return -32768;
    return $rtoi(r + ((r >= 0.0) ? 0.5 : -0.5));
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp, input int tol);
    checks++;
    if ((act - exp > tol) || (exp - act > tol)) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d (tol %0d) cycle=%0d", req, what, act, exp, tol, cyc);
    end
  endtask

  // one pair per cycle; compare outputs of the pair issued LAT cycles ago
  task automatic step(input real xr, input real yr, input logic vec, input logic en, input string tag);
    int s;
    int xi;
    int yi;
    real xa;
    real ya;
    real hh;
    real vv;
    @(negedge clk);
    if (cyc >= LAT) begin
      s = (cyc - LAT) % SLOTS;
      chk("R2", "out_vec", int'(out_vec), exp_vec[s], 0);
      chk("R2", "out_en", int'(out_en), exp_en[s], 0);
      chk(tag_h[s], "out_h", int'(out_h), exp_h[s], tol_h[s]);
      chk(tag_v[s], "out_v", int'(out_v), exp_v[s], tol_v[s]);
    end
    xi = qfix(xr);
    yi = qfix(yr);
    in_x   = 16'(xi);
    in_y   = 16'(yi);
    in_vec = vec;
    in_en  = en;
    xa = real'(xi) / FS;
    ya = real'(yi) / FS;
    s = cyc % SLOTS;
    exp_vec[s] = int'(vec);
    exp_en[s]  = int'(en);
    if (!en) begin
      exp_h[s] = 0; exp_v[s] = 0; tol_h[s] = 0; tol_v[s] = 0;
      tag_h[s] = "R7"; tag_v[s] = "R7";
    end else if (vec) begin
      hh = $sqrt(xa * xa + ya * ya);
      exp_h[s] = qfix(hh);
      tol_h[s] = (hh > 2.02) ? 0 : 6;
      tag_h[s] = (hh > 2.02) ? "R8" : tag;
      exp_v[s] = 0; tol_v[s] = 0; tag_v[s] = "R4";
      ang_m = $atan2(ya, xa);
    end else begin
      hh = xa * $cos(ang_m) + ya * $sin(ang_m);
      vv = -xa * $sin(ang_m) + ya * $cos(ang_m);
      exp_h[s] = qfix(hh); tol_h[s] = (hh > 2.02 || hh < -2.02) ? 0 : 16;
      exp_v[s] = qfix(vv); tol_v[s] = (vv > 2.02 || vv < -2.02) ? 0 : 16;
      tag_h[s] = (tol_h[s] == 0) ? "R8" : tag;
      tag_v[s] = (tol_v[s] == 0) ? "R8" : tag;
    end
    cyc++;
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog expired at cycle %0d", cyc);
    finish_run();
  end

  initial begin
    real radii [3];
    radii[0] = 0.5; radii[1] = 1.0; radii[2] = 1.9;
    repeat (4) @(negedge clk);
    // R1: outputs during reset
    chk("R1", "out_h in reset", int'(out_h), 0, 0);
    chk("R1", "out_en in reset", int'(out_en), 0, 0);
    rst = 1'b0;
    @(negedge clk);
    // R1: after release, nothing has crossed the pipeline yet
    chk("R1", "out_h after reset", int'(out_h), 0, 0);
    chk("R1", "out_v after reset", int'(out_v), 0, 0);
    chk("R1", "out_vec after reset", int'(out_vec), 0, 0);
    chk("R1", "out_en after reset", int'(out_en), 0, 0);

    // R3 / R5: sweep capture angles and radii, each followed by rotations
    for (int r = 0; r < 3; r++) begin
      for (int k = 0; k < 24; k++) begin
        real a;
        a = real'(k) * PI / 12.0;
        step(radii[r] * $cos(a), radii[r] * $sin(a), 1'b1, 1'b1, "R3");
        step(0.6, -0.3, 1'b0, 1'b1, "R5");
        step(-0.8, 0.5, 1'b0, 1'b1, "R5");
        step(0.9 * $cos(a + 1.0), 0.9 * $sin(2.0 * a), 1'b0, 1'b1, "R5");
      end
    end

    // R7: disabled vectoring pair must not move the angle; disabled rotation gives zero
    step(0.8660, 0.5, 1'b1, 1'b1, "R3");
    step(-0.5, 0.8660, 1'b1, 1'b0, "R7");
    step(0.7, 0.2, 1'b0, 1'b1, "R7");
    step(-0.4, -0.9, 1'b0, 1'b0, "R7");
    step(-0.3, 1.1, 1'b0, 1'b1, "R7");

    // R6: back-to-back angle changes with rotations in flight
    step(1.0, 1.0, 1'b1, 1'b1, "R3");
    step(0.5, 0.1, 1'b0, 1'b1, "R6");
    step(-0.2, 0.7, 1'b0, 1'b1, "R6");
    step(-1.2, -0.4, 1'b1, 1'b1, "R3");
    step(0.5, 0.1, 1'b0, 1'b1, "R6");
    step(0.3, -1.0, 1'b1, 1'b1, "R3");
    step(1.0, 0.6, 1'b0, 1'b1, "R6");
    step(-0.2, 0.7, 1'b0, 1'b1, "R6");
    for (int n = 0; n < 40; n++) begin
      step(1.2 * $cos(real'(n) * 0.4), 1.2 * $sin(real'(n) * 0.7), 1'b0, 1'b1, "R6");
    end

    // R8: saturation in both directions
    step(1.9, 1.9, 1'b1, 1'b1, "R8");
    step(-1.9, -1.9, 1'b0, 1'b1, "R8");
    step(1.9, 1.9, 1'b0, 1'b1, "R8");
    step(1.0, 1.0, 1'b1, 1'b1, "R3");
    step(-1.9, -1.9, 1'b0, 1'b1, "R8");
    step(1.9, 1.9, 1'b0, 1'b1, "R8");

    // drain with mixed control bits still forwarded
    for (int n = 0; n < LAT + 2; n++) begin
      step(0.0, 0.0, logic'(n % 2), 1'b0, "R7");
    end
    finish_run();
  end

endmodule